// File: doc/BRIEF.md
# Serial SAR Converter Reader

This block is the host side of a link to a 16-clock serial successive-approximation converter. It runs from a fast system clock and derives a chip select and a serial clock from it. The serial clock comes from a divider that sets each half period in system clocks. Data is shifted in from the converter's data line. The block drops the leading and trailing padding zeros and presents a resolved sample of BITS bits (10 or 8) together with a one-cycle valid pulse.

A command port starts one of three frames: a normal read, a short frame that places the converter in power-down, or a dummy wake-up frame. The block enforces the converter's timing rules internally. These are the delay from chip select to the first clock fall, a quiet gap after each frame, and a minimum wait after a wake-up before the next conversion. The busy flag tells the host when the next command will be taken. In 8-bit mode a build option ends read frames after 12 clocks to raise throughput.

Top module: `sar_reader`

## Requirements
- R1: After reset cs_n and sclk are high, busy is low and sample_valid is low.
- R2: A read (cmd_op 2'b00) returns the converter's serial bits 4 to 3+BITS, counting the bit present at the chip select fall as bit 0, as sample with the first of them in the most significant position. sample_valid pulses for one cycle on the same clock edge that raises cs_n.
- R3: A read frame contains exactly 16 falling sclk edges while cs_n is low. Each bit is taken on the sclk rise that follows its falling edge.
- R4: sclk stays high whenever cs_n is high. The first sclk fall comes at least DIV system clocks after cs_n falls. Each sclk low phase lasts at least DIV system clocks.
- R5: After any frame, cs_n stays high for at least QUIET_CYC system clocks before it can fall again, and busy is high from the cs_n rise until that gap ends.
- R6: A command offered while busy is high is ignored, and so is the reserved code 2'b11; neither changes the pins or starts a frame.
- R7: A power-down command (cmd_op 2'b01) gives exactly 3 falling sclk edges and then raises cs_n, which is inside the window from after the 2nd to before the 10th edge. It produces no sample_valid.
- R8: A wake command (cmd_op 2'b10) holds cs_n low for 11 falling sclk edges. The next cs_n fall comes at least WAKE_CYC system clocks after the dummy frame's cs_n fall, and busy stays high until then.
- R9: The first read after a wake frame produces no sample_valid. The read after it returns data normally.
- R10: With BITS=8 and SHORT8=1 a read frame has exactly 12 falling sclk edges and returns serial bits 4 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 2 | 00 read, 01 power-down, 10 wake, 11 reserved |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame, quiet gap or wake wait in progress |
| sample_valid | output | 1 | One-cycle pulse with a new sample |
| sample | output | BITS | Last resolved conversion result |

## Verification
The hardest situation to reach is a discarded sample. It needs a power-down frame, then a wake frame, then a read that waits out the wake delay, and that read must yield no valid pulse while the read after it does. The bench drives this full sequence in order. It timestamps every chip select edge, so it measures the wake gap from the dummy frame's fall rather than from its end. A converter model that shifts a known word makes any slip in the bit window show up as a wrong value.

// File: rtl/sar_reader.sv
module sar_reader #(
  parameter int BITS      = 10,
  parameter bit SHORT8    = 1'b0,
  parameter int DIV       = 2,
  parameter int QUIET_CYC = 4,
  parameter int WAKE_CYC  = 80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic            sdo,
  output logic            cs_n,
  output logic            sclk,
  output logic            busy,
  output logic            sample_valid,
  output logic [BITS-1:0] sample
);
  localparam int READ_CLKS = (BITS == 8 && SHORT8) ? 12 : 16;
  localparam int PD_CLKS   = 3;
  localparam int WAKE_CLKS = 11;
  localparam int LAST_BIT  = 3 + BITS;
  localparam int TMAX      = (DIV > QUIET_CYC) ? DIV : QUIET_CYC;
  localparam int TW        = $clog2(TMAX + 1);
  localparam int WW        = $clog2(WAKE_CYC + 1);

  localparam logic [1:0] OP_READ = 2'b00;
  localparam logic [1:0] OP_PD   = 2'b01;
  localparam logic [1:0] OP_WAKE = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_QUIET} st_t;

  st_t             st;
  logic [TW-1:0]   tmr;
  logic [4:0]      ecnt;
  logic [4:0]      frame_len;
  logic [1:0]      op_q;
  logic [BITS-1:0] sh;
  logic [WW-1:0]   wake_cnt;
  logic            discard;

  always_comb begin
    case (op_q)
      OP_PD:   frame_len = 5'(PD_CLKS);
      OP_WAKE: frame_len = 5'(WAKE_CLKS);
      default: frame_len = 5'(READ_CLKS);
    endcase
  end

  assign busy = (st != S_IDLE) || (wake_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cs_n         <= 1'b1;
      sclk         <= 1'b1;
      tmr          <= '0;
      ecnt         <= '0;
      op_q         <= OP_READ;
      sh           <= '0;
      sample       <= '0;
      sample_valid <= 1'b0;
      wake_cnt     <= '0;
      discard      <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (wake_cnt != '0) wake_cnt <= wake_cnt - WW'(1);
      case (st)
        S_IDLE:
          if (cmd_valid && !busy && cmd_op != 2'b11) begin
            op_q <= cmd_op;
            cs_n <= 1'b0;
            tmr  <= TW'(DIV - 1);
            ecnt <= '0;
            st   <= S_SETUP;
            if (cmd_op == OP_WAKE) wake_cnt <= WW'(WAKE_CYC);
          end
        S_SETUP:
          if (tmr == '0) begin
            sclk <= 1'b0;
            tmr  <= TW'(DIV - 1);
            ecnt <= ecnt + 5'd1;
            st   <= S_LOW;
          end else tmr <= tmr - TW'(1);
        S_LOW:
          if (tmr == '0) begin
            sclk <= 1'b1;
            tmr  <= TW'(DIV - 1);
            st   <= S_HIGH;
            if (ecnt <= 5'(LAST_BIT)) sh <= {sh[BITS-2:0], sdo};
          end else tmr <= tmr - TW'(1);
        S_HIGH:
          if (tmr == '0) begin
            if (ecnt == frame_len) begin
              cs_n <= 1'b1;
              tmr  <= TW'(QUIET_CYC - 1);
              st   <= S_QUIET;
              if (op_q == OP_READ) begin
                if (discard) discard <= 1'b0;
                else begin
                  sample       <= sh;
                  sample_valid <= 1'b1;
                end
              end
              if (op_q == OP_WAKE) discard <= 1'b1;
            end else begin
              sclk <= 1'b0;
              tmr  <= TW'(DIV - 1);
              ecnt <= ecnt + 5'd1;
              st   <= S_LOW;
            end
          end else tmr <= tmr - TW'(1);
        S_QUIET:
          if (tmr == '0) st <= S_IDLE;
          else tmr <= tmr - TW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  p_valid_at_cs_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $rose(cs_n));
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  p_busy_in_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> busy);
  p_start_when_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(!busy));

  generate
    if (DIV >= 2) begin : g_phase
      p_low_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |=> !sclk);
    end
  endgenerate
endmodule

// File: tb/test_sar_reader.sv
module adc_model (
  input  logic        cs_n,
  input  logic        sclk,
  input  logic [15:0] word,
  output logic        sdo,
  output int          falls,
  output int          frames
);
  int idx;
  logic [15:0] w;
  initial begin sdo = 1'b1; falls = 0; frames = 0; idx = 0; w = '0; end
  always @(negedge cs_n) begin
    w = word; idx = 0; falls = 0; frames++; sdo = word[15];
  end
  always @(negedge sclk) if (cs_n === 1'b0) begin
    falls++; idx++;
    sdo = (idx < 16) ? w[15 - idx] : 1'b1;
  end
  always @(posedge cs_n) sdo = 1'b1;
endmodule

module test_sar_reader;
  localparam int CLK_P = 10;
  localparam int DIV = 2, QUIET = 4, WAKE = 80;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0; logic [1:0] cmd_op = 0;
  logic sdo, cs_n, sclk, busy, sample_valid; logic [9:0] sample;
  logic [15:0] word = 0; int falls, frames;

  logic cv8 = 0; logic [1:0] op8 = 0;
  logic sdo8, cs8, sclk8, busy8, sv8; logic [7:0] smp8;
  logic [15:0] word8 = 0; int falls8, frames8;

  int checks = 0, errors = 0;
  int cyc = 0, t_rise = 0, t_fall = 0, ff_gap = 0, t_sf = 0;
  int min_quiet = 1000000, min_setup = 1000000, min_low = 1000000;
  int nvalid = 0, nvalid8 = 0; logic [9:0] last; logic [7:0] last8;
  bit first_pending = 0;

  localparam logic [9:0] VEC [6] = '{10'h3FF, 10'h000, 10'h2AA, 10'h155, 10'h201, 10'h0FE};

  sar_reader #(.BITS(10), .DIV(DIV), .QUIET_CYC(QUIET), .WAKE_CYC(WAKE)) i_sar_reader (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .sdo(sdo),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .sample_valid(sample_valid), .sample(sample));
  adc_model m10 (.cs_n(cs_n), .sclk(sclk), .word(word), .sdo(sdo), .falls(falls), .frames(frames));

  sar_reader #(.BITS(8), .SHORT8(1'b1), .DIV(DIV), .QUIET_CYC(QUIET), .WAKE_CYC(WAKE)) i_sar_reader_b8 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cv8), .cmd_op(op8), .sdo(sdo8),
    .cs_n(cs8), .sclk(sclk8), .busy(busy8), .sample_valid(sv8), .sample(smp8));
  adc_model m8 (.cs_n(cs8), .sclk(sclk8), .word(word8), .sdo(sdo8), .falls(falls8), .frames(frames8));

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) begin
    cyc++;
    if (sample_valid) begin nvalid++; last = sample; end
    if (sv8) begin nvalid8++; last8 = smp8; end
  end
  always @(posedge cs_n) t_rise = cyc;
  always @(negedge cs_n) begin
    if (cyc - t_rise < min_quiet) min_quiet = cyc - t_rise;
    ff_gap = cyc - t_fall; t_fall = cyc; first_pending = 1;
  end
  always @(negedge sclk) if (cs_n === 1'b0) begin
    if (first_pending && cyc - t_fall < min_setup) min_setup = cyc - t_fall;
    first_pending = 0; t_sf = cyc;
  end
  always @(posedge sclk) if (cs_n === 1'b0 && cyc - t_sf < min_low) min_low = cyc - t_sf;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic do_cmd(input logic [1:0] op);
    wait_idle();
    cmd_valid = 1; cmd_op = op;
    @(negedge clk) cmd_valid = 0;
    wait_idle();
  endtask

  task automatic do_cmd8(input logic [1:0] op);
    @(negedge clk);
    while (busy8) @(negedge clk);
    cv8 = 1; op8 = op;
    @(negedge clk) cv8 = 0;
    @(negedge clk);
    while (busy8) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nv, fr;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1, "R1 cs_n", int'(cs_n), 1);
    chk(sclk === 1'b1, "R1 sclk", int'(sclk), 1);
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(sample_valid === 1'b0, "R1 valid", int'(sample_valid), 0);
    rst_n = 1;

    foreach (VEC[i]) begin
      word = {4'b0000, VEC[i], 2'b00};
      nv = nvalid;
      do_cmd(2'b00);
      chk(nvalid == nv + 1 && last == VEC[i], "R2 data", int'(last), int'(VEC[i]));
      chk(falls == 16, "R3 falls", falls, 16);
    end
    chk(min_setup >= DIV, "R4 setup", min_setup, DIV);
    chk(min_low >= DIV, "R4 low phase", min_low, DIV);
    chk(min_quiet >= QUIET, "R5 quiet", min_quiet, QUIET);

    word = {4'b0000, 10'h1C3, 2'b00};
    fr = frames; nv = nvalid;
    wait_idle();
    cmd_valid = 1; cmd_op = 2'b00;
    @(negedge clk) cmd_op = 2'b01;
    repeat (20) @(negedge clk);
    cmd_valid = 0;
    wait_idle();
    chk(frames == fr + 1, "R6 busy ignore frames", frames - fr, 1);
    chk(falls == 16 && last == 10'h1C3, "R6 busy ignore frame kind", falls, 16);

    fr = frames;
    cmd_valid = 1; cmd_op = 2'b11;
    @(negedge clk) cmd_valid = 0;
    repeat (20) @(negedge clk);
    chk(frames == fr && busy === 1'b0 && cs_n === 1'b1, "R6 reserved op", frames - fr, 0);

    nv = nvalid;
    do_cmd(2'b01);
    chk(falls == 3, "R7 pd falls", falls, 3);
    chk(nvalid == nv, "R7 pd no sample", nvalid - nv, 0);

    do_cmd(2'b10);
    chk(falls == 11, "R8 wake falls", falls, 11);
    word = {4'b0000, 10'h2F0, 2'b00};
    nv = nvalid;
    do_cmd(2'b00);
    chk(ff_gap >= WAKE, "R8 wake gap", ff_gap, WAKE);
    chk(nvalid == nv, "R9 discard", nvalid - nv, 0);
    do_cmd(2'b00);
    chk(nvalid == nv + 1 && last == 10'h2F0, "R9 next valid", int'(last), 'h2F0);

    word8 = {4'b0000, 8'hA5, 4'b0000};
    do_cmd8(2'b00);
    chk(falls8 == 12, "R10 falls", falls8, 12);
    chk(nvalid8 == 1 && last8 == 8'hA5, "R10 data", int'(last8), 'hA5);
    word8 = {4'b0000, 8'h3C, 4'b1111};
    do_cmd8(2'b00);
    chk(nvalid8 == 2 && last8 == 8'h3C, "R10 data2", int'(last8), 'h3C);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule